// File: doc/BRIEF.md
# Mode-Aware Opcode Class Decoder

This block watches a stream of x86 instruction bytes, one byte per clock when a valid strobe is high. A static mode input selects between 32-bit legacy/compatibility decoding and 64-bit long-mode decoding. For each instruction the block reads the leading bytes and emits one record.

The record gives one of eight class codes, a 4-bit register number, and the REX prefix fields captured before the opcode. The class codes are: register increment, register decrement, r/m increment, r/m decrement, segment-RPL adjust, sign-extending dword move, invalid-in-this-mode, and other. The block exists because the same byte values mean different things in the two modes. In 32-bit mode the 0x40..0x4F row is a set of one-byte register increments and decrements. In long mode that row is a REX prefix. Opcode 0x63 also changes meaning with the mode.

The block is meant as a front-end classifier for a code-scanning engine, for example one that guesses which mode a code fragment was built for. It does not decode instruction length past the bytes listed below. It does not handle other legacy prefixes, displacements or immediates. The mode input may only change while reset is held.

Top module: `opcode_mode_classifier`

## Requirements
- R1: A synchronous reset clears the record valid output and returns the block to the opcode-expecting state with no REX held, so the first byte after reset is taken as a prefix or an opcode.
- R2: In 32-bit mode, a byte 0x40+r gives class 1 (register increment) and a byte 0x48+r gives class 2 (register decrement), after that one byte. The register field is r, a 3-bit value with bit 3 of the field cleared.
- R3: In long mode, bytes 0x40..0x4F are never classified. Each one is held as a REX prefix with W at bit 3, R at bit 2, X at bit 1 and B at bit 0, and the next byte is the opcode. When REX bytes follow each other, only the last one counts. The record shows whether a REX was seen and its four bits. A REX never carries over to the next instruction.
- R4: In both modes, opcode 0xFF consumes a ModRM byte. A reg field (bits 5:3) of 0 gives class 3 (r/m increment) and a reg field of 1 gives class 4 (r/m decrement). The register number is {REX.B, ModRM bits 2:0}. Any other reg field gives class 0 with register 0. So FF C0 reports class 3 on register 0, and FF C8 reports class 4 on register 0.
- R5: Opcode 0x63 consumes a ModRM byte. In 32-bit mode it gives class 5 (segment-RPL adjust). In long mode it gives class 6 (sign-extending move), and the record's W bit shows whether the dword is widened to a qword. In both modes the register number is {REX.B, ModRM bits 2:0}.
- R6: The segment push/pop opcodes 0x06, 0x07, 0x0E, 0x16, 0x17, 0x1E and 0x1F give class 7 (invalid) in long mode and class 0 in 32-bit mode.
- R7: The decimal-adjust opcodes 0x27, 0x2F, 0x37, 0x3F, 0xD4 and 0xD5 give class 7 in long mode and class 0 in 32-bit mode.
- R8: In both modes, escape byte 0x0F consumes one more byte of any value and gives class 0. This covers the FS/GS push/pop pairs 0F A0, 0F A1, 0F A8 and 0F A9. A second byte in the 0x40..0x4F range is not taken as a REX prefix.
- R9: In both modes, every other opcode, including 0x9E and 0x9F (flags to and from AH), gives class 0 with register 0 after one byte.
- R10: The record is valid for exactly one cycle: the cycle after the clock edge that accepts the instruction's last byte. Cycles with the byte strobe low produce no record and leave a partly read instruction intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| longMode | input | 1 | 1 selects 64-bit decoding, 0 selects 32-bit decoding; change only during reset |
| byteValid | input | 1 | byteIn carries an instruction byte this cycle |
| byteIn | input | 8 | Instruction byte |
| resValid | output | 1 | One-cycle pulse marking a record |
| resClass | output | 3 | Class code (0..7) |
| resReg | output | 4 | Register number for classes 1..6, else 0 |
| resRexSeen | output | 1 | A REX prefix came before the opcode |
| resRexW | output | 1 | Captured REX.W |
| resRexR | output | 1 | Captured REX.R |
| resRexX | output | 1 | Captured REX.X |
| resRexB | output | 1 | Captured REX.B |

## Verification
The bench covers cases where a slip in decoding would shift or mislabel bytes:
- Two REX bytes in a row, where keeping the first instead of the last gives a wrong B or W.
- A REX byte used as a ModRM byte or as an escape's second byte. If it were captured as a prefix, the record would be lost and the byte stream would slip.
- A ModRM reg field outside 0 and 1, which a loose decoder would report as a decrement.
- Idle cycles in the middle of an instruction and a reset that lands mid-instruction. Either can leave a stale pending opcode that turns the next byte into an operand.
- Opcodes just beside the removed ranges, which catch an invalid table that is too wide or applied in the wrong mode.

// File: rtl/ocls_pkg.sv
package ocls_pkg;

  localparam int BYTE_W  = 8;
  localparam int REG_W   = 4;
  localparam int FIELD_W = 3;
  localparam int REX_W   = 4;

  typedef enum logic [2:0] {
    CLS_OTHER   = 3'd0,
    CLS_INC_REG = 3'd1,
    CLS_DEC_REG = 3'd2,
    CLS_INC_RM  = 3'd3,
    CLS_DEC_RM  = 3'd4,
    CLS_ARPL    = 3'd5,
    CLS_MOVSXD  = 3'd6,
    CLS_INVALID = 3'd7
  } instClass_e;

  typedef enum logic [1:0] {
    REG_NONE  = 2'd0,
    REG_LOW3  = 2'd1,
    REG_MODRM = 2'd2
  } regSel_e;

  typedef enum logic [1:0] {
    ST_OPCODE   = 2'd0,
    ST_MODRM_FF = 2'd1,
    ST_MODRM_63 = 2'd2,
    ST_ESCAPE   = 2'd3
  } ctrlState_e;

  // Decoded view of the current byte, produced by the datapath
  typedef struct packed {
    logic               isPrefix;
    logic               isShortInc;
    logic               isShortDec;
    logic               isGroupFF;
    logic               isOp63;
    logic               isEscape;
    logic               isDropped;
    logic [FIELD_W-1:0] modrmReg;
  } byteInfo_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       rexLoad;
    logic       issue;
    instClass_e cls;
    regSel_e    regSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/ocls_ctrl.sv
module ocls_ctrl
  import ocls_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        longMode,
  input  logic        byteValid,
  input  byteInfo_t   info,
  output ctrlStrobe_t strobe
);

  ctrlState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_OPCODE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext      = state;
    strobe.rexLoad = 1'b0;
    strobe.issue   = 1'b0;
    strobe.cls     = CLS_OTHER;
    strobe.regSel  = REG_NONE;
    if (byteValid) begin
      unique case (state)
        ST_OPCODE: begin
          if (info.isPrefix) begin
            strobe.rexLoad = 1'b1;
          end else if (info.isGroupFF) begin
            stateNext = ST_MODRM_FF;
          end else if (info.isOp63) begin
            stateNext = ST_MODRM_63;
          end else if (info.isEscape) begin
            stateNext = ST_ESCAPE;
          end else begin
            strobe.issue = 1'b1;
            if (info.isShortInc) begin
              strobe.cls    = CLS_INC_REG;
              strobe.regSel = REG_LOW3;
            end else if (info.isShortDec) begin
              strobe.cls    = CLS_DEC_REG;
              strobe.regSel = REG_LOW3;
            end else if (info.isDropped) begin
              strobe.cls = CLS_INVALID;
            end
          end
        end
        ST_MODRM_FF: begin
          strobe.issue = 1'b1;
          stateNext    = ST_OPCODE;
          if (info.modrmReg == 3'd0) begin
            strobe.cls    = CLS_INC_RM;
            strobe.regSel = REG_MODRM;
          end else if (info.modrmReg == 3'd1) begin
            strobe.cls    = CLS_DEC_RM;
            strobe.regSel = REG_MODRM;
          end
        end
        ST_MODRM_63: begin
          strobe.issue  = 1'b1;
          stateNext     = ST_OPCODE;
          strobe.cls    = longMode ? CLS_MOVSXD : CLS_ARPL;
          strobe.regSel = REG_MODRM;
        end
        ST_ESCAPE: begin
          strobe.issue = 1'b1;
          stateNext    = ST_OPCODE;
        end
        default: stateNext = ST_OPCODE;
      endcase
    end
  end

  // R4
  // operand bytes always end the instruction
  operand_byte_returns_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_OPCODE && byteValid) |=> (state == ST_OPCODE));

  // R10
  // idle cycles leave a partial instruction untouched
  idle_holds_state_chk: assert property (@(posedge clk) disable iff (rst)
    !byteValid |=> $stable(state));

endmodule

// File: rtl/ocls_dpath.sv
module ocls_dpath
  import ocls_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              longMode,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteIn,
  input  ctrlStrobe_t       strobe,
  output byteInfo_t         info,
  output logic              resValid,
  output logic [2:0]        resClass,
  output logic [REG_W-1:0]  resReg,
  output logic              resRexSeen,
  output logic [REX_W-1:0]  resRex
);

  logic             rexValid;
  logic [REX_W-1:0] rexBits;
  logic             segOp, bcdOp;
  instClass_e       resClassQ;
  logic [REG_W-1:0] regNext;

  // Byte decode
  always_comb begin
    segOp = 1'b0;
    bcdOp = 1'b0;
    case (byteIn)
      8'h06, 8'h07, 8'h0E, 8'h16, 8'h17, 8'h1E, 8'h1F: segOp = 1'b1;
      8'h27, 8'h2F, 8'h37, 8'h3F, 8'hD4, 8'hD5:        bcdOp = 1'b1;
      default: ;
    endcase
  end

  assign info.isPrefix   = longMode  && (byteIn[7:4] == 4'h4);
  assign info.isShortInc = !longMode && (byteIn[7:3] == 5'b01000);
  assign info.isShortDec = !longMode && (byteIn[7:3] == 5'b01001);
  assign info.isGroupFF  = (byteIn == 8'hFF);
  assign info.isOp63     = (byteIn == 8'h63);
  assign info.isEscape   = (byteIn == 8'h0F);
  assign info.isDropped  = longMode && (segOp || bcdOp);
  assign info.modrmReg   = byteIn[5:3];

  // REX holding register
  always_ff @(posedge clk) begin
    if (rst) begin
      rexValid <= 1'b0;
      rexBits  <= '0;
    end else if (strobe.rexLoad) begin
      rexValid <= 1'b1;
      rexBits  <= byteIn[REX_W-1:0];
    end else if (strobe.issue) begin
      rexValid <= 1'b0;
      rexBits  <= '0;
    end
  end

  // Register number selection
  always_comb begin
    unique case (strobe.regSel)
      REG_LOW3:  regNext = {1'b0, byteIn[2:0]};
      REG_MODRM: regNext = {rexValid & rexBits[0], byteIn[2:0]};
      default:   regNext = '0;
    endcase
  end

  // Result record
  always_ff @(posedge clk) begin
    if (rst) begin
      resValid   <= 1'b0;
      resClassQ  <= CLS_OTHER;
      resReg     <= '0;
      resRexSeen <= 1'b0;
      resRex     <= '0;
    end else begin
      resValid <= strobe.issue;
      if (strobe.issue) begin
        resClassQ  <= strobe.cls;
        resReg     <= regNext;
        resRexSeen <= rexValid;
        resRex     <= rexBits;
      end
    end
  end

  assign resClass = resClassQ;

  // R10
  // a record only follows an accepted byte
  result_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
    resValid |-> $past(byteValid));

  // R3
  // no prefix is ever held in 32-bit mode
  rex_only_long_chk: assert property (@(posedge clk) disable iff (rst)
    !longMode |-> !rexValid);

  // R2
  // short register forms only in 32-bit mode, 3-bit register
  short_form_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (resValid && (resClassQ == CLS_INC_REG || resClassQ == CLS_DEC_REG))
      |-> (!longMode && !resReg[3]));

  // R5
  // 0x63 meaning follows the mode
  arpl_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (resValid && resClassQ == CLS_ARPL) |-> !longMode);

  // R5
  movsxd_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (resValid && resClassQ == CLS_MOVSXD) |-> longMode);

  // R6
  // invalid class only in long mode
  invalid_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (resValid && resClassQ == CLS_INVALID) |-> longMode);

  // R10
  // record is a single-cycle pulse unless a byte was accepted
  pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (resValid && !$past(byteValid, 1)) |-> 1'b0);

  wire unusedValid = byteValid;

endmodule

// File: rtl/opcode_mode_classifier.sv
module opcode_mode_classifier
  import ocls_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       longMode,
  input  logic       byteValid,
  input  logic [7:0] byteIn,
  output logic       resValid,
  output logic [2:0] resClass,
  output logic [3:0] resReg,
  output logic       resRexSeen,
  output logic       resRexW,
  output logic       resRexR,
  output logic       resRexX,
  output logic       resRexB
);

  byteInfo_t        info;
  ctrlStrobe_t      strobe;
  logic [REX_W-1:0] rexOut;

  ocls_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .longMode  (longMode),
    .byteValid (byteValid),
    .info      (info),
    .strobe    (strobe)
  );

  ocls_dpath u_dpath (
    .clk        (clk),
    .rst        (rst),
    .longMode   (longMode),
    .byteValid  (byteValid),
    .byteIn     (byteIn),
    .strobe     (strobe),
    .info       (info),
    .resValid   (resValid),
    .resClass   (resClass),
    .resReg     (resReg),
    .resRexSeen (resRexSeen),
    .resRex     (rexOut)
  );

  assign resRexW = rexOut[3];
  assign resRexR = rexOut[2];
  assign resRexX = rexOut[1];
  assign resRexB = rexOut[0];

endmodule

// File: tb/opcode_mode_classifier_tb.sv
module opcode_mode_classifier_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       longMode = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteIn = 8'h00;
  logic       resValid;
  logic [2:0] resClass;
  logic [3:0] resReg;
  logic       resRexSeen, resRexW, resRexR, resRexX, resRexB;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opcode_mode_classifier u_dut (
    .clk(clk), .rst(rst), .longMode(longMode), .byteValid(byteValid),
    .byteIn(byteIn), .resValid(resValid), .resClass(resClass),
    .resReg(resReg), .resRexSeen(resRexSeen), .resRexW(resRexW),
    .resRexR(resRexR), .resRexX(resRexX), .resRexB(resRexB)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit isSeg(input logic [7:0] b);
    return b inside {8'h06, 8'h07, 8'h0E, 8'h16, 8'h17, 8'h1E, 8'h1F};
  endfunction

  function automatic bit isBcd(input logic [7:0] b);
    return b inside {8'h27, 8'h2F, 8'h37, 8'h3F, 8'hD4, 8'hD5};
  endfunction

  function automatic logic [2:0] expClass(input bit lm, input logic [7:0] op, input logic [7:0] mr);
    if (!lm && op[7:3] == 5'b01000) return 3'd1;
    if (!lm && op[7:3] == 5'b01001) return 3'd2;
    if (op == 8'hFF) return (mr[5:3] == 3'd0) ? 3'd3 : (mr[5:3] == 3'd1) ? 3'd4 : 3'd0;
    if (op == 8'h63) return lm ? 3'd6 : 3'd5;
    if (lm && (isSeg(op) || isBcd(op))) return 3'd7;
    return 3'd0;
  endfunction

  function automatic string reqOf(input logic [2:0] c, input logic [7:0] op);
    case (c)
      3'd1, 3'd2: return "R2";
      3'd3, 3'd4: return "R4";
      3'd5, 3'd6: return "R5";
      3'd7:       return isSeg(op) ? "R6" : "R7";
      default:    return (op == 8'h0F) ? "R8" : "R9";
    endcase
  endfunction

  // one byte accepted at the next posedge, sampled at the following negedge
  task automatic sendByte(input logic [7:0] b);
    byteValid = 1'b1;
    byteIn    = b;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R10 idle", resValid, 1'b0);
    end
  endtask

  task automatic doReset(input bit lm);
    rst = 1'b1;
    longMode = lm;
    byteValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // nRex REX bytes (long mode only), opcode, optional second byte
  task automatic runInstr(input int nRex, input logic [7:0] rx0, input logic [7:0] rx1,
                          input logic [7:0] op, input logic [7:0] sec, input string tag);
    logic [2:0]  c;
    logic [3:0]  r;
    logic [3:0]  rexLast;
    logic [11:0] exp, act;
    bit twoByte;
    rexLast = (nRex == 2) ? rx1[3:0] : (nRex == 1) ? rx0[3:0] : 4'h0;
    twoByte = (op == 8'hFF) || (op == 8'h63) || (op == 8'h0F);
    c = expClass(longMode, op, sec);
    case (c)
      3'd1, 3'd2:             r = {1'b0, op[2:0]};
      3'd3, 3'd4, 3'd5, 3'd6: r = {rexLast[0], sec[2:0]};
      default:                r = 4'h0;
    endcase
    exp = {c, r, (nRex > 0), rexLast};
    if (nRex > 0) begin sendByte(rx0); check("R3 prefix", resValid, 1'b0); end
    if (nRex > 1) begin sendByte(rx1); check("R3 prefix", resValid, 1'b0); end
    sendByte(op);
    if (twoByte) begin
      check({tag, " first byte"}, resValid, 1'b0);
      sendByte(sec);
    end
    check({tag, " valid"}, resValid, 1'b1);
    act = {resClass, resReg, resRexSeen, resRexW, resRexR, resRexX, resRexB};
    check(tag, act, exp);
  endtask

  function automatic logic [7:0] pickOp(input bit lm);
    logic [7:0] pool [0:19];
    logic [7:0] b;
    pool = '{8'h40, 8'h4F, 8'hFF, 8'h63, 8'h0F, 8'h06, 8'h07, 8'h0E, 8'h16, 8'h17,
             8'h1E, 8'h1F, 8'h27, 8'h2F, 8'h37, 8'h3F, 8'hD4, 8'hD5, 8'h9E, 8'h9F};
    do begin
      if ($urandom_range(1, 0) == 1) b = pool[$urandom_range(19, 0)];
      else                           b = 8'($urandom_range(255, 0));
      if (!lm && b[7:4] == 4'h4) b[2:0] = 3'($urandom_range(7, 0));
    end while (lm && b[7:4] == 4'h4);
    return b;
  endfunction

  task automatic randomRun(input int n);
    for (int i = 0; i < n; i++) begin
      int nr;
      logic [7:0] op, sec, r0, r1;
      nr  = longMode ? $urandom_range(2, 0) : 0;
      r0  = {4'h4, 4'($urandom_range(15, 0))};
      r1  = {4'h4, 4'($urandom_range(15, 0))};
      op  = pickOp(longMode);
      sec = 8'($urandom_range(255, 0));
      runInstr(nr, r0, r1, op, sec, reqOf(expClass(longMode, op, sec), op));
      if ($urandom_range(3, 0) == 0) idle($urandom_range(2, 1));
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    doReset(1'b0);
    // R1
    check("R1 reset valid", resValid, 1'b0);
    // 32-bit directed
    runInstr(0, 8'h0, 8'h0, 8'h40, 8'h00, "R2");
    runInstr(0, 8'h0, 8'h0, 8'h4F, 8'h00, "R2");
    runInstr(0, 8'h0, 8'h0, 8'hFF, 8'hC0, "R4");
    runInstr(0, 8'h0, 8'h0, 8'hFF, 8'hC8, "R4");
    runInstr(0, 8'h0, 8'h0, 8'hFF, 8'hD0, "R4");
    runInstr(0, 8'h0, 8'h0, 8'h63, 8'hC1, "R5");
    runInstr(0, 8'h0, 8'h0, 8'h06, 8'h00, "R6");
    runInstr(0, 8'h0, 8'h0, 8'h27, 8'h00, "R7");
    runInstr(0, 8'h0, 8'h0, 8'h0F, 8'hA0, "R8");
    runInstr(0, 8'h0, 8'h0, 8'h9E, 8'h00, "R9");
    // R10: idle gap in the middle of FF xx
    sendByte(8'hFF);
    idle(3);
    sendByte(8'hC8);
    check("R10 after gap valid", resValid, 1'b1);
    check("R10 after gap record", {resClass, resReg}, {3'd4, 4'd0});
    idle(1);
    // R1: reset mid-instruction drops the pending opcode
    sendByte(8'hFF);
    doReset(1'b0);
    check("R1 reset mid", resValid, 1'b0);
    runInstr(0, 8'h0, 8'h0, 8'h43, 8'h00, "R1");
    randomRun(300);

    // long mode directed
    doReset(1'b1);
    check("R1 reset valid long", resValid, 1'b0);
    runInstr(1, 8'h40, 8'h0, 8'hFF, 8'hC0, "R4");
    runInstr(1, 8'h41, 8'h0, 8'hFF, 8'hC8, "R4");
    runInstr(1, 8'h48, 8'h0, 8'h63, 8'hC1, "R5");
    runInstr(0, 8'h0, 8'h0, 8'h63, 8'hC1, "R5");
    runInstr(2, 8'h41, 8'h48, 8'hFF, 8'hC0, "R3");
    runInstr(0, 8'h0, 8'h0, 8'h90, 8'h00, "R3");
    runInstr(0, 8'h0, 8'h0, 8'h06, 8'h00, "R6");
    runInstr(0, 8'h0, 8'h0, 8'h1F, 8'h00, "R6");
    runInstr(0, 8'h0, 8'h0, 8'hD4, 8'h00, "R7");
    runInstr(0, 8'h0, 8'h0, 8'h0F, 8'hA8, "R8");
    runInstr(0, 8'h0, 8'h0, 8'h0F, 8'h40, "R8");
    runInstr(0, 8'h0, 8'h0, 8'hFF, 8'h4F, "R4");
    runInstr(0, 8'h0, 8'h0, 8'h9F, 8'h00, "R9");
    runInstr(0, 8'h0, 8'h0, 8'h08, 8'h00, "R9");
    randomRun(300);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule